// File: doc/BRIEF.md
# ADC Calibration Sequencer and Output Corrector

This block sits between a delta-sigma modulator's raw conversion stream and the rest of the chip. On a calibrate command it steers the analog input multiplexer, waits out a fixed calibration window, captures one conversion per phase and turns it into an offset or gain coefficient. In normal operation it corrects every raw result with the stored coefficients and delivers a clipped code in either two's complement or offset binary, 24 or 32 bits wide.

There are three calibration modes. The internal mode first shorts the modulator inputs to measure its own offset, then switches them to the reference to measure full scale. It does not see the front-end amplifier. The two system modes leave the inputs routed to the pins, so the user must apply a zero or full-scale level. These modes capture an offset or a gain that covers the whole signal path. Each calibration conversion should be taken at the modulator's slowest rate. The window length is `PHASE_CYC` clock cycles. It is meant to be set so that one phase spans 100 ms. The internal mode spans two phases (200 ms) and each system mode spans one.

Top module: `adc_cal_corr`

## Requirements
- R1: After reset, `busy`, `cal_done` and `out_valid` are 0 and `mux_sel` is 00. All offsets are 0 and all gains are 1.0, so a raw value passes through unchanged.
- R2: A calibration starts when `cmd_valid` and `cmd_cal` are both 1 while idle. The 2-bit mode selects the sequence: 00 internal, 01 system zero, 10 system full scale. Mode 11, or `cmd_cal` = 0, starts nothing.
- R3: The internal mode first drives `mux_sel` = 01 (shorted) for PHASE_CYC cycles and stores the first raw result of that phase as the internal offset. It then drives `mux_sel` = 10 (reference) for PHASE_CYC cycles and sets the internal gain to FSMAX / (ref − internal offset).
- R4: System zero calibration keeps `mux_sel` = 00 for PHASE_CYC cycles. It stores the first result of the phase, taken after the internal corrections, as the system offset, and it changes no other coefficient.
- R5: System full-scale calibration keeps `mux_sel` = 00 for PHASE_CYC cycles. It sets the system gain to FSMAX divided by the first result of the phase, taken after internal correction and system offset. A gain is set to its largest code when the divisor is ≤ 0 or the quotient exceeds that code.
- R6: `busy` is high for exactly 2·PHASE_CYC cycles in the internal mode and PHASE_CYC cycles in either system mode. It rises the cycle after the command. `cal_done` is high for one cycle: the first cycle `busy` is low.
- R7: A command that arrives while `busy` is high is ignored. It neither lengthens the sequence nor changes any coefficient.
- R8: Correction runs in this order: subtract the internal offset, multiply by the internal gain, subtract the system offset, multiply by the system gain. Gains are unsigned GW-bit numbers with 2 integer bits, so 1.0 = 2^(GW−2). Products are shifted right arithmetically (floor), and every step saturates to the signed DW-bit range.
- R9: `coef_dis` bits bypass single steps: bit 0 the internal offset, bit 1 the internal gain, bit 2 the system offset, bit 3 the system gain.
- R10: `out_valid` pulses one cycle after each `raw_valid` that is taken while `busy` is low, and never while `busy` is high. With `fmt_wide` = 0 the code sits in bits 23:0 and bits 31:24 are 0. With `fmt_wide` = 1 the code is the value shifted left 8. With `fmt_ob` = 1 the top bit of the chosen width is inverted, which gives offset binary.
- R11: Results beyond full scale clip. Positive full scale gives 7FFFFF in two's complement or FFFFFF in offset binary. Negative full scale gives 800000 or 000000. Midscale in offset binary is 800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_cal | input | 1 | Calibrate flag of the command |
| cmd_mode | input | 2 | Calibration mode select |
| coef_dis | input | 4 | Per-coefficient bypass bits |
| fmt_ob | input | 1 | 1 = offset binary, 0 = two's complement |
| fmt_wide | input | 1 | 1 = 32-bit code, 0 = 24-bit code |
| raw_valid | input | 1 | Raw conversion strobe |
| raw_data | input | DW | Raw signed conversion result |
| mux_sel | output | 2 | Input mux request: 00 pins, 01 shorted, 10 reference |
| busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | One-cycle end-of-calibration pulse |
| out_valid | output | 1 | Corrected code strobe |
| out_code | output | OW | Corrected, formatted code |

## Verification
The corrected code is registered once, so it is due one cycle after `raw_valid`. The bench drives inputs on the falling edge and reads the code on the next falling edge. Calibration state is counted per falling edge from the command. `busy` must read high for exactly one or two windows, and `cal_done` must appear on the first low read and be gone on the next. Calibration samples are placed a fixed number of cycles into each phase, and `mux_sel` is sampled in the second cycle of each phase. Coefficients are never read directly. Their effect is judged from later conversions against a bench model of the correction chain.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    MUX_PINS  = 2'b00,
    MUX_SHORT = 2'b01,
    MUX_REF   = 2'b10
  } mux_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INT_ZERO,
    ST_INT_FULL,
    ST_SYS_ZERO,
    ST_SYS_FULL
  } seq_state_e;

  // bypass bit positions in coef_dis
  localparam int DIS_INT_OFF = 0;
  localparam int DIS_INT_GAIN = 1;
  localparam int DIS_SYS_OFF = 2;
  localparam int DIS_SYS_GAIN = 3;

endpackage

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int PHASE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_cal,
  input  logic [1:0] cmd_mode,
  input  logic       raw_valid,
  output logic       busy,
  output logic       done,
  output logic [1:0] mux_sel,
  output logic       cap_int_off,
  output logic       cap_int_gain,
  output logic       cap_sys_off,
  output logic       cap_sys_gain
);

  localparam int CW = (PHASE_CYC > 2) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  seq_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            got_q, got_d;
  logic            done_q, done_d;
  logic            start, phase_end, cnt_en, take;

  always_comb begin
    start     = (state_q == ST_IDLE) && cmd_valid && cmd_cal && (cmd_mode != 2'b11);
    phase_end = (state_q != ST_IDLE) && (cnt_q == LAST);
    cnt_en    = start || (state_q != ST_IDLE);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    got_d   = got_q;
    done_d  = 1'b0;
    if (start) begin
      cnt_d = '0;
      got_d = 1'b0;
      case (cmd_mode)
        2'b00:   state_d = ST_INT_ZERO;
        2'b01:   state_d = ST_SYS_ZERO;
        default: state_d = ST_SYS_FULL;
      endcase
    end else if (state_q != ST_IDLE) begin
      if (raw_valid) got_d = 1'b1;
      if (phase_end) begin
        cnt_d = '0;
        got_d = 1'b0;
        if (state_q == ST_INT_ZERO) begin
          state_d = ST_INT_FULL;
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      got_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        got_q <= got_d;
      end
    end
  end

  always_comb begin
    take         = raw_valid && !got_q;
    cap_int_off  = take && (state_q == ST_INT_ZERO);
    cap_int_gain = take && (state_q == ST_INT_FULL);
    cap_sys_off  = take && (state_q == ST_SYS_ZERO);
    cap_sys_gain = take && (state_q == ST_SYS_FULL);
    busy         = (state_q != ST_IDLE);
    done         = done_q;
    case (state_q)
      ST_INT_ZERO: mux_sel = MUX_SHORT;
      ST_INT_FULL: mux_sel = MUX_REF;
      default:     mux_sel = MUX_PINS;
    endcase
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_end) |=> (state_q == $past(state_q)));

  // R3
  mux_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != MUX_PINS) |-> busy);

  // R3
  int_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_INT_FULL) && ($past(state_q) != ST_INT_FULL)) |-> ($past(state_q) == ST_INT_ZERO));

endmodule

// File: rtl/adc_cal_fix.sv
module adc_cal_fix
  import adc_cal_pkg::*;
#(
  parameter int DW = 24,
  parameter int GW = 24
) (
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] int_off,
  input  logic [GW-1:0] int_gain,
  input  logic [DW-1:0] sys_off,
  input  logic [GW-1:0] sys_gain,
  input  logic [3:0]    dis,
  output logic [DW-1:0] x1,
  output logic [DW-1:0] x2,
  output logic [DW-1:0] x3,
  output logic [DW-1:0] x4
);

  localparam int PW = DW + GW + 1;
  localparam logic signed [PW-1:0] VMAX = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] VMIN = -(PW'(1) <<< (DW - 1));

  function automatic logic [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > VMAX)      clip = VMAX[DW-1:0];
    else if (v < VMIN) clip = VMIN[DW-1:0];
    else               clip = v[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] sat_sub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] ae, be;
    ae = $signed({{(PW-DW){a[DW-1]}}, a});
    be = $signed({{(PW-DW){b[DW-1]}}, b});
    sat_sub = clip(ae - be);
  endfunction

  function automatic logic [DW-1:0] sat_mul(input logic [DW-1:0] a, input logic [GW-1:0] g);
    logic signed [PW-1:0] ae, ge, p;
    ae = $signed({{(PW-DW){a[DW-1]}}, a});
    ge = $signed({{(PW-GW){1'b0}}, g});
    p  = ae * ge;
    sat_mul = clip(p >>> (GW - 2));
  endfunction

  always_comb begin
    x1 = dis[DIS_INT_OFF]  ? raw : sat_sub(raw, int_off);
    x2 = dis[DIS_INT_GAIN] ? x1  : sat_mul(x1, int_gain);
    x3 = dis[DIS_SYS_OFF]  ? x2  : sat_sub(x2, sys_off);
    x4 = dis[DIS_SYS_GAIN] ? x3  : sat_mul(x3, sys_gain);
  end

endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef #(
  parameter int DW = 24,
  parameter int GW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          cap_int_off,
  input  logic          cap_int_gain,
  input  logic          cap_sys_off,
  input  logic          cap_sys_gain,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] x1,
  input  logic [DW-1:0] x2,
  input  logic [DW-1:0] x3,
  output logic [DW-1:0] int_off,
  output logic [GW-1:0] int_gain,
  output logic [DW-1:0] sys_off,
  output logic [GW-1:0] sys_gain
);

  localparam int NW = DW + GW;
  localparam logic [GW-1:0] G_ONE = {2'b01, {(GW-2){1'b0}}};
  localparam logic [GW-1:0] G_MAX = '1;
  localparam logic [NW-1:0] NUM   = ((NW'(1) << (DW - 1)) - NW'(1)) << (GW - 2);

  logic [DW-1:0] io_q, so_q;
  logic [GW-1:0] ig_q, sg_q;
  logic [DW-1:0] den_s;
  logic          den_pos;
  logic [NW-1:0] den_u, quo;
  logic [GW-1:0] g_new;

  // one shared divider: the two gain captures never coincide
  always_comb begin
    den_s   = cap_int_gain ? x1 : x3;
    den_pos = !den_s[DW-1] && (den_s != '0);
    den_u   = den_pos ? {{(NW-DW){1'b0}}, den_s} : NW'(1);
    quo     = NUM / den_u;
    g_new   = (!den_pos || (quo > {{(NW-GW){1'b0}}, G_MAX})) ? G_MAX : quo[GW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q <= '0;
      ig_q <= G_ONE;
      so_q <= '0;
      sg_q <= G_ONE;
    end else begin
      if (cap_int_off)  io_q <= raw;
      if (cap_int_gain) ig_q <= g_new;
      if (cap_sys_off)  so_q <= x2;
      if (cap_sys_gain) sg_q <= g_new;
    end
  end

  assign int_off  = io_q;
  assign int_gain = ig_q;
  assign sys_off  = so_q;
  assign sys_gain = sg_q;

  // R7
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(io_q) && $stable(ig_q) && $stable(so_q) && $stable(sg_q)));

  // R4
  sys_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_sys_off |=> ($stable(io_q) && $stable(ig_q) && $stable(sg_q)));

endmodule

// File: rtl/adc_cal_fmt.sv
module adc_cal_fmt #(
  parameter int DW = 24,
  parameter int OW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] val,
  input  logic          ob,
  input  logic          wide,
  output logic          valid,
  output logic [OW-1:0] code
);

  logic [OW-1:0] narrow_c, wide_c, code_d, code_q;
  logic          valid_q;

  generate
    if (OW > DW) begin : g_pad
      always_comb begin
        narrow_c = {{(OW-DW){1'b0}}, ob ^ val[DW-1], val[DW-2:0]};
        wide_c   = {ob ^ val[DW-1], val[DW-2:0], {(OW-DW){1'b0}}};
      end
    end else begin : g_same
      always_comb begin
        narrow_c = {ob ^ val[DW-1], val[DW-2:0]};
        wide_c   = narrow_c;
      end
    end
  endgenerate

  always_comb code_d = wide ? wide_c : narrow_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= en;
      if (en) code_q <= code_d;
    end
  end

  assign valid = valid_q;
  assign code  = code_q;

  // R10
  out_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(en));

endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr #(
  parameter int DW        = 24,
  parameter int OW        = 32,
  parameter int GW        = 24,
  parameter int PHASE_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_cal,
  input  logic [1:0]    cmd_mode,
  input  logic [3:0]    coef_dis,
  input  logic          fmt_ob,
  input  logic          fmt_wide,
  input  logic          raw_valid,
  input  logic [DW-1:0] raw_data,
  output logic [1:0]    mux_sel,
  output logic          busy,
  output logic          cal_done,
  output logic          out_valid,
  output logic [OW-1:0] out_code
);

  logic          cap_io, cap_ig, cap_so, cap_sg;
  logic [DW-1:0] io, so, x1, x2, x3, x4;
  logic [GW-1:0] ig, sg;
  logic          fmt_en;

  adc_cal_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cal(cmd_cal),
    .cmd_mode(cmd_mode), .raw_valid(raw_valid), .busy(busy), .done(cal_done),
    .mux_sel(mux_sel), .cap_int_off(cap_io), .cap_int_gain(cap_ig),
    .cap_sys_off(cap_so), .cap_sys_gain(cap_sg)
  );

  adc_cal_fix #(.DW(DW), .GW(GW)) u_fix (
    .raw(raw_data), .int_off(io), .int_gain(ig), .sys_off(so), .sys_gain(sg),
    .dis(coef_dis), .x1(x1), .x2(x2), .x3(x3), .x4(x4)
  );

  adc_cal_coef #(.DW(DW), .GW(GW)) u_coef (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cap_int_off(cap_io),
    .cap_int_gain(cap_ig), .cap_sys_off(cap_so), .cap_sys_gain(cap_sg),
    .raw(raw_data), .x1(x1), .x2(x2), .x3(x3),
    .int_off(io), .int_gain(ig), .sys_off(so), .sys_gain(sg)
  );

  assign fmt_en = raw_valid && !busy;

  adc_cal_fmt #(.DW(DW), .OW(OW)) u_fmt (
    .clk(clk), .rst_n(rst_n), .en(fmt_en), .val(x4), .ob(fmt_ob),
    .wide(fmt_wide), .valid(out_valid), .code(out_code)
  );

  // R10
  no_out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !out_valid);

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_cal));

endmodule

// File: tb/tb_adc_cal_corr.sv
module tb_adc_cal_corr;

  localparam int DW = 24;
  localparam int OW = 32;
  localparam int GW = 24;
  localparam int P  = 16;
  localparam longint FSMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint FSMIN = -(64'sd1 <<< (DW - 1));
  localparam longint GMAX  = (64'sd1 <<< GW) - 1;
  localparam longint GONE  = 64'sd1 <<< (GW - 2);

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_cal, fmt_ob, fmt_wide, raw_valid;
  logic [1:0] cmd_mode;
  logic [3:0] dis;
  logic [DW-1:0] raw_data;
  logic [1:0] mux_sel;
  logic busy, cal_done, out_valid;
  logic [OW-1:0] out_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  longint m_io = 0, m_ig = GONE, m_so = 0, m_sg = GONE;

  always #2.5 clk = ~clk;

  adc_cal_corr #(.DW(DW), .OW(OW), .GW(GW), .PHASE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cal(cmd_cal),
    .cmd_mode(cmd_mode), .coef_dis(dis), .fmt_ob(fmt_ob), .fmt_wide(fmt_wide),
    .raw_valid(raw_valid), .raw_data(raw_data), .mux_sel(mux_sel), .busy(busy),
    .cal_done(cal_done), .out_valid(out_valid), .out_code(out_code)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint clip(input longint v);
    if (v > FSMAX) return FSMAX;
    if (v < FSMIN) return FSMIN;
    return v;
  endfunction

  function automatic longint csub(input longint a, input longint b);
    return clip(a - b);
  endfunction

  function automatic longint cmul(input longint a, input longint g);
    return clip((a * g) >>> (GW - 2));
  endfunction

  function automatic longint gcalc(input longint d);
    longint q;
    if (d <= 0) return GMAX;
    q = (FSMAX <<< (GW - 2)) / d;
    return (q > GMAX) ? GMAX : q;
  endfunction

  // R8 R9: bench model of the correction chain, stopping after step 'upto'
  function automatic longint chain(input longint r, input int upto);
    longint x;
    x = r;
    if (!dis[0]) x = csub(x, m_io);
    if (upto == 1) return x;
    if (!dis[1]) x = cmul(x, m_ig);
    if (upto == 2) return x;
    if (!dis[2]) x = csub(x, m_so);
    if (upto == 3) return x;
    if (!dis[3]) x = cmul(x, m_sg);
    return x;
  endfunction

  function automatic longint fmtc(input longint v, input bit ob, input bit wide);
    longint c;
    if (wide) begin
      c = (v <<< (OW - DW)) & 64'hFFFF_FFFF;
      if (ob) c = c ^ 64'h8000_0000;
    end else begin
      c = v & 64'hFF_FFFF;
      if (ob) c = c ^ 64'h80_0000;
    end
    return c;
  endfunction

  function automatic longint sx(input logic [DW-1:0] r);
    return longint'($signed(r));
  endfunction

  task automatic conv(input logic [DW-1:0] r, input string req);
    longint e;
    @(negedge clk);
    raw_valid = 1'b1;
    raw_data  = r;
    e = fmtc(chain(sx(r), 4), fmt_ob, fmt_wide);
    @(negedge clk);
    raw_valid = 1'b0;
    chk(out_valid === 1'b1 && longint'(out_code) == e, req, longint'(out_code), e);
  endtask

  task automatic run_cal(input logic [1:0] mode, input logic [DW-1:0] s0,
                         input logic [DW-1:0] s1, input bit inject);
    int nph, total, bcnt;
    logic [1:0] mx0, mx1;
    bit ovbad;
    longint v;
    nph = (mode == 2'b00) ? 2 : 1;
    total = nph * P;
    bcnt = 0;
    ovbad = 1'b0;
    mx0 = 2'b11;
    mx1 = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_cal = 1'b1; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < total; i++) begin
      if (busy) bcnt++;
      if (i == 1) mx0 = mux_sel;
      if (i == P + 1) mx1 = mux_sel;
      if (i == 3 || i == P + 3) begin
        raw_valid = 1'b0;
        if (out_valid) ovbad = 1'b1;
      end
      if (i == 2) begin raw_valid = 1'b1; raw_data = s0; end
      if (i == P + 2 && nph == 2) begin raw_valid = 1'b1; raw_data = s1; end
      if (i == 5) begin raw_valid = 1'b1; raw_data = s1; end
      if (i == 6) raw_valid = 1'b0;
      if (inject && i == 4) begin cmd_valid = 1'b1; cmd_mode = 2'b01; end
      if (inject && i == 5) cmd_valid = 1'b0;
      @(negedge clk);
    end
    // R6 busy length and done timing
    chk(bcnt == total, "R6 busy length", bcnt, total);
    chk(busy === 1'b0 && cal_done === 1'b1, "R6 done on busy fall", {busy, cal_done}, 2'b01);
    // R10 no output during calibration
    chk(!ovbad, "R10 out_valid while busy", ovbad, 0);
    if (mode == 2'b00) begin
      chk(mx0 == 2'b01, "R3 shorted phase mux", mx0, 2'b01);
      chk(mx1 == 2'b10, "R3 reference phase mux", mx1, 2'b10);
      m_io = sx(s0);
      m_ig = gcalc(chain(sx(s1), 1));
    end else if (mode == 2'b01) begin
      chk(mx0 == 2'b00, "R4 system zero keeps pins", mx0, 2'b00);
      m_so = chain(sx(s0), 2);
    end else begin
      chk(mx0 == 2'b00, "R5 system full keeps pins", mx0, 2'b00);
      v = chain(sx(s0), 3);
      m_sg = gcalc(v);
    end
    @(negedge clk);
    chk(cal_done === 1'b0, "R6 done one cycle", cal_done, 0);
  endtask

  task automatic no_start(input bit cal, input logic [1:0] mode, input string req);
    int b;
    b = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_cal = cal; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (busy || cal_done) b++;
      @(negedge clk);
    end
    chk(b == 0, req, b, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint e;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_cal = 1'b0; cmd_mode = 2'b00; dis = 4'b0000;
    fmt_ob = 1'b0; fmt_wide = 1'b0; raw_valid = 1'b0; raw_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && cal_done === 1'b0 && out_valid === 1'b0 && mux_sel === 2'b00,
        "R1 reset outputs", {busy, cal_done, out_valid, mux_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 identity coefficients
    conv(24'h123456, "R1 identity pass");
    chk(out_code == 32'h0012_3456, "R1 identity literal", longint'(out_code), 32'h0012_3456);
    fmt_ob = 1'b1;
    conv(24'h000000, "R11 midscale offset binary");
    chk(out_code == 32'h0080_0000, "R11 midscale literal", longint'(out_code), 32'h0080_0000);
    fmt_wide = 1'b1;
    conv(24'hFFFFFF, "R10 wide offset binary");
    fmt_ob = 1'b0;
    conv(24'h800001, "R10 wide two's complement");

    // R2 ignored commands
    no_start(1'b1, 2'b11, "R2 mode 11 no start");
    no_start(1'b0, 2'b00, "R2 cal flag 0 no start");

    // R3 R7 internal calibration with a command injected while busy
    run_cal(2'b00, 24'h00_3A98, 24'h70_0000, 1'b1);
    fmt_wide = 1'b0;
    conv(24'h40_0000, "R3 internal coefficients applied");
    // R4 system zero
    run_cal(2'b01, 24'hFF_D8F0, 24'h0, 1'b0);
    conv(24'h20_0000, "R4 system offset applied");
    // R5 system full scale
    run_cal(2'b10, 24'h60_0000, 24'h0, 1'b0);
    conv(24'h55_0000, "R5 system gain applied");
    conv(24'hAB_0000, "R8 negative path");

    // R9 each bypass bit alone
    for (int k = 0; k < 4; k++) begin
      dis = 4'(1 << k);
      conv(24'h31_4159, "R9 single bypass");
    end
    dis = 4'b0000;

    // R11 clipping via a large system gain
    run_cal(2'b10, 24'h00_1000, 24'h0, 1'b0);
    conv(24'h7F_0000, "R11 positive clip");
    chk(out_code == 32'h007F_FFFF, "R11 positive clip literal", longint'(out_code), 32'h007F_FFFF);
    fmt_ob = 1'b1;
    conv(24'h80_0000, "R11 negative clip offset binary");
    chk(out_code == 32'h0000_0000, "R11 negative clip literal", longint'(out_code), 0);
    conv(24'h7F_FFFF, "R11 positive clip offset binary");
    chk(out_code == 32'h00FF_FFFF, "R11 positive ob literal", longint'(out_code), 32'h00FF_FFFF);

    // R5 non-positive divisor gives maximum gain
    fmt_ob = 1'b0;
    run_cal(2'b10, 24'hF0_0000, 24'h0, 1'b0);
    conv(24'h00_1234, "R5 max gain on negative divisor");

    // restore moderate system gain
    run_cal(2'b10, 24'h70_0000, 24'h0, 1'b0);

    // R8 R9 R10 random mix
    for (int n = 0; n < 300; n++) begin
      dis      = 4'($urandom_range(0, 15));
      fmt_ob   = 1'($urandom_range(0, 1));
      fmt_wide = 1'($urandom_range(0, 1));
      conv(DW'($urandom), "R8 random conversion");
    end

    // R3 second internal calibration with random samples
    dis = 4'b0000;
    run_cal(2'b00, DW'($urandom_range(0, 40000)), DW'(24'h68_0000 + $urandom_range(0, 65535)), 1'b0);
    for (int n = 0; n < 40; n++) begin
      fmt_ob   = 1'($urandom_range(0, 1));
      fmt_wide = 1'($urandom_range(0, 1));
      conv(DW'($urandom), "R3 random after recalibration");
    end
    e = 0;

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule